// File: doc/BRIEF.md
# Fixed-Priority DMA Channel Arbiter

Eight DMA channels share one bus master. Each channel raises a pending flag and offers a group length: how many bus beats it wants the master to carry out before arbitration runs again. The arbiter grants the master to the pending channel with the lowest number. Once granted, a channel keeps the master until every beat of its group has completed, even if a channel with a lower number becomes pending in the meantime. A group is never longer than four 32-bit words, so that is also the longest time a more urgent channel can be held off. Bus beats appear here only as a completion strobe.

When the last beat of a group completes, the arbiter picks again in that same clock edge, so a waiting channel takes over with no idle cycle in between. The block also merges the per-channel interrupt flags into one interrupt line.

The controller has two states. In `ST_IDLE` no group runs. In `ST_XFER` a group is in progress. The transitions are:
- `T_START`: `ST_IDLE` to `ST_XFER` when any channel is pending.
- `T_HOLD`: stay in `ST_XFER` while the group still has beats left.
- `T_HANDOFF`: stay in `ST_XFER` on the last beat when some channel is pending, and load a new grant.
- `T_RELEASE`: `ST_XFER` to `ST_IDLE` on the last beat when nothing is pending.

Top module: `dma_chan_arbiter`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears `grant` to zero, `grant_idx` to 0 and `busy` to 0, including in the middle of a group.
- R2: From idle, the edge after one or more `req` bits are high sets `busy`, and `grant` becomes one-hot on the lowest-numbered pending channel. `grant_idx` carries that channel's number.
- R3: While a group is in progress, `grant` does not change, whatever `req` does, until the group's last beat completes.
- R4: Channel i's group length is read from `grp_len[3*i+2:3*i]` at the edge where the grant is given. The group ends on the edge where the N-th `beat_done` pulse is seen while `busy` is high.
- R5: A group length of 0 counts as 1 beat. A length greater than 4 counts as 4 beats.
- R6: At the edge that completes a group's last beat, if any `req` bit is high, the highest-priority pending channel is granted at once. `busy` stays high, with no idle cycle. This includes the channel that just finished.
- R7: At the edge that completes a group's last beat, if no `req` bit is high, `busy` falls and `grant` and `grant_idx` return to zero.
- R8: A `beat_done` pulse while `busy` is low has no effect. It neither starts a group nor shortens the next group.
- R9: `irq_out` is high exactly when at least one bit of `irq_in` is high. It is combinational, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 8 | Per-channel pending flags; bit 0 has the highest priority |
| grp_len | input | 24 | Per-channel group length, 3 bits per channel; channel i in bits 3i+2..3i |
| beat_done | input | 1 | One bus beat of the current group completed this cycle |
| irq_in | input | 8 | Per-channel interrupt requests |
| grant | output | 8 | One-hot grant of the bus master |
| grant_idx | output | 3 | Number of the granted channel; 0 when idle |
| busy | output | 1 | A group is in progress |
| irq_out | output | 1 | OR of all per-channel interrupt requests |

## Verification
The grant sequence is tried with several request patterns:
- Two channels pending at once, which tells strict priority apart from arrival order.
- More urgent channels arriving partway through a four-beat group, which separates non-preemptive holding from immediate switching.
- A waiting channel at the final beat, which exposes any idle bubble at a handoff.
- The same channel staying pending, which shows whether the finishing channel can be granted again.

Group lengths of 0 and 7, and beat pulses while idle, show whether the beat count is clamped and whether stray beats are dropped. A reset in the middle of a group and a sweep of interrupt flag patterns complete the set.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_XFER = 1'b1
    } arb_state_e;

endpackage

// File: rtl/dma_arb_prio_pick.sv
module dma_arb_prio_pick #(
    parameter int NUM_CH = 8,
    parameter int IDX_W  = $clog2(NUM_CH)
) (
    input  logic [NUM_CH-1:0] req,
    output logic [NUM_CH-1:0] win,
    output logic [IDX_W-1:0]  win_idx,
    output logic              any_req
);

    // seen[i] is high when any channel numbered below i is pending
    logic [NUM_CH:0] seen;

    assign seen[0] = 1'b0;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chain
        assign win[g]    = req[g] & ~seen[g];
        assign seen[g+1] = seen[g] | req[g];
    end

    assign any_req = seen[NUM_CH];

    always_comb begin
        win_idx = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (win[i]) begin
                win_idx = win_idx | IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/dma_arb_beat_ctr.sv
module dma_arb_beat_ctr #(
    parameter int CNT_W     = 3,
    parameter int MAX_BEATS = 4,
    parameter int REM_W     = $clog2(MAX_BEATS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_len,
    input  logic             active,
    input  logic             beat,
    output logic             last_beat
);

    logic [REM_W-1:0] rem_q;
    logic [REM_W-1:0] eff_len;

    // zero means one beat; anything beyond the cap is cut to the cap
    always_comb begin
        if (load_len == '0) begin
            eff_len = REM_W'(1);
        end else if (32'(load_len) > MAX_BEATS) begin
            eff_len = REM_W'(MAX_BEATS);
        end else begin
            eff_len = REM_W'(load_len);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
        end else if (load) begin
            rem_q <= eff_len;
        end else if (active && beat && rem_q != '0) begin
            rem_q <= rem_q - REM_W'(1);
        end
    end

    assign last_beat = active && beat && (rem_q == REM_W'(1));

endmodule

// File: rtl/dma_arb_irq_merge.sv
module dma_arb_irq_merge #(
    parameter int NUM_CH = 8
) (
    input  logic [NUM_CH-1:0] irq_in,
    output logic              irq_out
);

    assign irq_out = |irq_in;

endmodule

// File: rtl/dma_chan_arbiter.sv
module dma_chan_arbiter
    import dma_arb_pkg::*;
#(
    parameter int NUM_CH    = 8,
    parameter int CNT_W     = 3,
    parameter int MAX_BEATS = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NUM_CH-1:0]       req,
    input  logic [NUM_CH*CNT_W-1:0] grp_len,
    input  logic                    beat_done,
    input  logic [NUM_CH-1:0]       irq_in,
    output logic [NUM_CH-1:0]       grant,
    output logic [$clog2(NUM_CH)-1:0] grant_idx,
    output logic                    busy,
    output logic                    irq_out
);

    localparam int IDX_W = $clog2(NUM_CH);

    arb_state_e state_q, state_d;

    logic [NUM_CH-1:0] pick_win;
    logic [IDX_W-1:0]  pick_idx;
    logic              pick_any;
    logic              group_last;
    logic              take_grant;
    logic              drop_grant;
    logic [CNT_W-1:0]  pick_len;

    logic [NUM_CH-1:0] grant_q;
    logic [IDX_W-1:0]  idx_q;

    dma_arb_prio_pick #(
        .NUM_CH (NUM_CH),
        .IDX_W  (IDX_W)
    ) u_pick (
        .req     (req),
        .win     (pick_win),
        .win_idx (pick_idx),
        .any_req (pick_any)
    );

    assign pick_len = grp_len[pick_idx*CNT_W +: CNT_W];

    dma_arb_beat_ctr #(
        .CNT_W     (CNT_W),
        .MAX_BEATS (MAX_BEATS)
    ) u_beats (
        .clk       (clk),
        .rst       (rst),
        .load      (take_grant),
        .load_len  (pick_len),
        .active    (state_q == ST_XFER),
        .beat      (beat_done),
        .last_beat (group_last)
    );

    dma_arb_irq_merge #(
        .NUM_CH (NUM_CH)
    ) u_irq (
        .irq_in  (irq_in),
        .irq_out (irq_out)
    );

    // next-state and transition decode
    always_comb begin
        state_d    = state_q;
        take_grant = 1'b0;
        drop_grant = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (pick_any) begin          // T_START
                    state_d    = ST_XFER;
                    take_grant = 1'b1;
                end
            end
            ST_XFER: begin
                if (group_last) begin
                    if (pick_any) begin      // T_HANDOFF
                        state_d    = ST_XFER;
                        take_grant = 1'b1;
                    end else begin           // T_RELEASE
                        state_d    = ST_IDLE;
                        drop_grant = 1'b1;
                    end
                end                          // else T_HOLD
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // output registers
    always_ff @(posedge clk) begin
        if (rst) begin
            grant_q <= '0;
            idx_q   <= '0;
        end else if (take_grant) begin
            grant_q <= pick_win;
            idx_q   <= pick_idx;
        end else if (drop_grant) begin
            grant_q <= '0;
            idx_q   <= '0;
        end
    end

    assign grant     = grant_q;
    assign grant_idx = idx_q;
    assign busy      = (state_q == ST_XFER);

endmodule

// File: rtl/dma_arb_checker.sv
module dma_arb_checker #(
    parameter int NUM_CH = 8,
    parameter int IDX_W  = 3
) (
    input logic              clk,
    input logic              rst,
    input logic [NUM_CH-1:0] req,
    input logic              beat_done,
    input logic [NUM_CH-1:0] grant,
    input logic [IDX_W-1:0]  grant_idx,
    input logic              busy
);

    p_reset_clear_r1: assert property (@(posedge clk)
        $past(rst) |-> (grant == '0 && !busy && grant_idx == '0));

    p_onehot_grant_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    p_busy_has_grant_r2: assert property (@(posedge clk) disable iff (rst)
        busy == (grant != '0));

    p_idx_matches_r2: assert property (@(posedge clk) disable iff (rst)
        busy |-> grant[grant_idx]);

    p_grant_was_pending_r2: assert property (@(posedge clk) disable iff (rst)
        (grant != '0 && grant != $past(grant)) |-> ((grant & $past(req)) != '0));

    p_no_preempt_r3: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && grant != $past(grant)) |-> $past(beat_done));

    p_idle_beat_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        $past(!busy && req == '0) |-> !busy);

endmodule

bind dma_chan_arbiter dma_arb_checker #(
    .NUM_CH (NUM_CH),
    .IDX_W  (IDX_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req       (req),
    .beat_done (beat_done),
    .grant     (grant),
    .grant_idx (grant_idx),
    .busy      (busy)
);

// File: tb/sim_dma_chan_arbiter.sv
`timescale 1ns/1ps
module sim_dma_chan_arbiter;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  req = '0;
    logic [23:0] grp_len = '0;
    logic        beat_done = 1'b0;
    logic [7:0]  irq_in = '0;
    logic [7:0]  grant;
    logic [2:0]  grant_idx;
    logic        busy;
    logic        irq_out;

    int n_chk = 0;
    int n_bad = 0;

    int q_ch[$];
    int q_len[$];

    always #2.5 clk = ~clk;

    dma_chan_arbiter u0 (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .grp_len   (grp_len),
        .beat_done (beat_done),
        .irq_in    (irq_in),
        .grant     (grant),
        .grant_idx (grant_idx),
        .busy      (busy),
        .irq_out   (irq_out)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic expect_group(input int ch, input int beats);
        q_ch.push_back(ch);
        q_len.push_back(beats);
    endtask

    task automatic set_len(input int ch, input int len);
        grp_len[ch*3 +: 3] = 3'(len);
    endtask

    task automatic beats(input int n);
        for (int i = 0; i < n; i++) begin
            beat_done = 1'b1;
            tick();
        end
        beat_done = 1'b0;
    endtask

    // scoreboard monitor: sampled at the falling edge, after the rising edge settled
    bit need_new  = 1'b1;
    bit prev_busy = 1'b0;
    int cur_ch    = 0;
    int cur_len   = 0;
    int cur_cnt   = 0;

    always @(negedge clk) begin
        if (rst) begin
            need_new  = 1'b1;
            prev_busy = 1'b0;
            cur_cnt   = 0;
        end else begin
            if (prev_busy && beat_done && !need_new) begin
                cur_cnt++;
                if (cur_cnt == cur_len) need_new = 1'b1;
            end
            if (busy && need_new) begin
                if (q_ch.size() == 0) begin
                    check("R2 unexpected grant", int'(grant), 0);
                    need_new = 1'b0;
                    cur_len  = 1000;
                end else begin
                    cur_ch  = q_ch.pop_front();
                    cur_len = q_len.pop_front();
                    check("R2/R6 grant one-hot", int'(grant), 1 << cur_ch);
                    check("R2 grant_idx", int'(grant_idx), cur_ch);
                    need_new = 1'b0;
                end
                cur_cnt = 0;
            end else if (busy) begin
                if (grant != 8'(1 << cur_ch))
                    check("R3 grant held in group", int'(grant), 1 << cur_ch);
            end else if (!need_new && prev_busy) begin
                check("R4/R5 group ended early, beats", cur_cnt, cur_len);
                need_new = 1'b1;
            end
            prev_busy = busy;
        end
    end

    initial begin
        // watchdog
        #200000;
        check("watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        tick();
        tick();
        check("R1 reset grant", int'(grant), 0);
        check("R1 reset busy", int'(busy), 0);
        check("R1 reset idx", int'(grant_idx), 0);
        rst = 1'b0;
        tick();

        // R2 priority among two, R6 handoff, R7 release
        set_len(5, 2);
        set_len(7, 3);
        req = 8'b1010_0000;
        expect_group(5, 2);
        expect_group(7, 3);
        tick();
        req[5] = 1'b0;
        beats(2);
        check("R6 busy kept at handoff", int'(busy), 1);
        req[7] = 1'b0;
        beats(3);
        check("R7 busy low after release", int'(busy), 0);
        check("R7 grant zero after release", int'(grant), 0);
        check("R7 idx zero after release", int'(grant_idx), 0);

        // R3 no preemption, then priority at handoff
        set_len(6, 4);
        set_len(0, 1);
        set_len(1, 1);
        req = 8'b0100_0000;
        expect_group(6, 4);
        expect_group(0, 1);
        expect_group(1, 1);
        tick();
        req[6] = 1'b0;
        beats(1);
        req[0] = 1'b1;
        req[1] = 1'b1;
        tick();
        check("R3 lower channel keeps grant", int'(grant), 1 << 6);
        beats(3);
        req[0] = 1'b0;
        beats(1);
        req[1] = 1'b0;
        beats(1);
        check("R7 idle after chain", int'(busy), 0);

        // R5 length 0 -> 1 beat, length 7 -> 4 beats
        set_len(3, 0);
        req = 8'b0000_1000;
        expect_group(3, 1);
        tick();
        req = '0;
        beats(1);
        check("R5 zero length is one beat", int'(busy), 0);
        set_len(2, 7);
        req = 8'b0000_0100;
        expect_group(2, 4);
        tick();
        req = '0;
        beats(3);
        check("R5 long length still busy after 3", int'(busy), 1);
        beats(1);
        check("R5 long length capped at 4", int'(busy), 0);

        // R8 beats while idle are dropped
        beats(3);
        check("R8 idle beats start nothing", int'(busy), 0);
        check("R8 idle beats grant", int'(grant), 0);
        set_len(4, 2);
        req = 8'b0001_0000;
        expect_group(4, 2);
        tick();
        req = '0;
        beats(1);
        check("R8 group not shortened", int'(busy), 1);
        beats(1);

        // R6 same channel granted again back to back
        set_len(2, 1);
        req = 8'b0000_0100;
        expect_group(2, 1);
        expect_group(2, 1);
        tick();
        beats(1);
        check("R6 same channel regranted", int'(busy), 1);
        req = '0;
        beats(1);
        check("R7 idle after regrant", int'(busy), 0);

        // R9 interrupt merge
        irq_in = 8'h00; #1; check("R9 irq none", int'(irq_out), 0);
        irq_in = 8'h80; #1; check("R9 irq ch7", int'(irq_out), 1);
        irq_in = 8'h01; #1; check("R9 irq ch0", int'(irq_out), 1);
        irq_in = 8'hFF; #1; check("R9 irq all", int'(irq_out), 1);
        irq_in = 8'h00; #1; check("R9 irq cleared", int'(irq_out), 0);

        // R1 reset in the middle of a group
        set_len(7, 4);
        req = 8'b1000_0000;
        expect_group(7, 4);
        tick();
        req = '0;
        beats(1);
        rst = 1'b1;
        tick();
        check("R1 mid-group reset busy", int'(busy), 0);
        check("R1 mid-group reset grant", int'(grant), 0);
        rst = 1'b0;
        tick();
        tick();

        check("scoreboard drained", q_ch.size(), 0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule